// File: doc/BRIEF.md
# Serial Core Status and Interrupt Unit

This unit gathers the error and service events of a serial transfer core and turns them into one interrupt line and a transfer-complete indication. Error events land in one or more banks of sticky flags. Each bank has its own per-bit enable register. An operational register holds the input/output service flags and the input/output max-done flags. Two live FIFO level bits appear beside them in the same register. Software acknowledges any sticky flag by writing a one to its position, so writing back a value just read clears exactly the bits that were seen.

A transfer-mode field selects FIFO, block or one of two DMA styles of handling. A service-mask register is honoured only in the two DMA styles, where it keeps the service flags from raising the interrupt. In FIFO and block styles the mask has no effect. The interrupt is the registered OR of every enabled error flag and every unmasked operational flag. The transfer-complete output is high whenever max-input-done or any error flag is set.

Top module: `sci_status_irq`

## Requirements
- R1: After reset every flag, enable, mask and mode field is zero, every readable address returns zero, and irq_o is low.
- R2: A pulse on an error event bit sets the matching flag on the next clock only when that bit's enable (bank enable address, bit i matches event bit i) was set before the edge; a pulse on a disabled bit leaves the flag at zero.
- R3: Writing a bank's flag address (address 2*b for bank b) clears exactly the flag bits written as one; bits written as zero keep their value.
- R4: When a write-one clear and a new event hit the same flag bit in the same cycle, the bit is set afterwards; this holds for error flags and operational flags.
- R5: Operational register (address 2*NUM_BANKS): bit 0 input service, bit 1 output service, bit 2 max-input-done, bit 3 max-output-done are set by their event pulses and cleared by writing one; bit 4 reads out_fifo_full and bit 5 reads in_fifo_nempty live, and writes to bits 4 and 5 change nothing.
- R6: Mode field (address 2*NUM_BANKS+2, bits 1:0): 0 FIFO, 1 block, 2 and 3 DMA. The mask (address 2*NUM_BANKS+1, bit 0 input service, bit 1 output service) suppresses those flags as interrupt causes only in modes 2 and 3; done flags are never masked.
- R7: irq_o is high in the cycle after the flag state holds at least one enabled error flag or unmasked operational flag, and low in the cycle after it holds none.
- R8: xfer_done_o is high whenever max-input-done or any error flag (enabled or not at read time) is set.
- R9: Enable, mask and mode registers read back the value written in their low bits; all unused bits of every address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Read data for rd_addr, combinational |
| err_evt | input | NUM_BANKS*3 | Error event pulses, 3 bits per bank: 0 output overrun, 1 input underrun, 2 output underrun |
| in_svc_evt | input | 1 | Input service event pulse |
| out_svc_evt | input | 1 | Output service event pulse |
| in_done_evt | input | 1 | Max-input-done event pulse |
| out_done_evt | input | 1 | Max-output-done event pulse |
| out_fifo_full | input | 1 | Live output FIFO full level |
| in_fifo_nempty | input | 1 | Live input FIFO not-empty level |
| irq_o | output | 1 | Registered interrupt line |
| xfer_done_o | output | 1 | Transfer complete indication |

## Verification
The write-one clear and a fresh event on the same flag bit can fall in the same cycle, both for an error bank and for the operational register. The bench provokes it by driving the clearing write and the event pulse at the same clock edge, then reads the register back at the next cycle and expects the bit still set and the interrupt still high. A behavioural model updated on every clock judges every other cycle, including mode switches between FIFO, block and both DMA styles with a non-zero mask.

// File: rtl/sci_status_pkg.sv
package sci_status_pkg;

    typedef enum logic [1:0] {
        XM_FIFO  = 2'd0,
        XM_BLOCK = 2'd1,
        XM_DMA_A = 2'd2,
        XM_DMA_B = 2'd3
    } xfer_mode_e;

    localparam int ERR_W        = 3;
    localparam int ERR_OUT_OVR  = 0;
    localparam int ERR_IN_UNDR  = 1;
    localparam int ERR_OUT_UNDR = 2;

    localparam int OP_IN_SVC    = 0;
    localparam int OP_OUT_SVC   = 1;
    localparam int OP_IN_DONE   = 2;
    localparam int OP_OUT_DONE  = 3;
    localparam int OP_OUT_FULL  = 4;
    localparam int OP_IN_NEMPTY = 5;
    localparam int OP_STICKY_W  = 4;
    localparam int OP_READ_W    = 6;
    localparam int MASK_W       = 2;
    localparam int MODE_W       = 2;

    function automatic logic mode_is_dma(xfer_mode_e m);
        return (m == XM_DMA_A) || (m == XM_DMA_B);
    endfunction

endpackage

// File: rtl/sci_err_bank.sv
module sci_err_bank
    import sci_status_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_clr_we,
    input  logic             en_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [ERR_W-1:0] evt,
    output logic [ERR_W-1:0] flags_o,
    output logic [ERR_W-1:0] en_o,
    output logic             cause_o
);

    typedef struct packed {
        logic [ERR_W-1:0] flags;
        logic [ERR_W-1:0] en;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_clr_we) begin
            st_d.flags = st_q.flags & ~wdata[ERR_W-1:0];
        end
        // a new enabled event overrides a clear of the same bit
        st_d.flags = st_d.flags | (evt & st_q.en);
        if (en_we) begin
            st_d.en = wdata[ERR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign cause_o = |(st_q.flags & st_q.en);

endmodule

// File: rtl/sci_op_reg.sv
module sci_op_reg
    import sci_status_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_clr_we,
    input  logic                   mask_we,
    input  logic                   mode_we,
    input  logic [REG_W-1:0]       wdata,
    input  logic                   in_svc_evt,
    input  logic                   out_svc_evt,
    input  logic                   in_done_evt,
    input  logic                   out_done_evt,
    output logic [OP_STICKY_W-1:0] op_o,
    output logic [MASK_W-1:0]      mask_o,
    output xfer_mode_e             mode_o,
    output logic                   cause_o
);

    typedef struct packed {
        logic [OP_STICKY_W-1:0] op;
        logic [MASK_W-1:0]      mask;
        xfer_mode_e             mode;
    } op_st_t;

    op_st_t                 st_d, st_q;
    logic [OP_STICKY_W-1:0] set_vec;
    logic [OP_STICKY_W-1:0] eff_mask;

    always_comb begin
        set_vec              = '0;
        set_vec[OP_IN_SVC]   = in_svc_evt;
        set_vec[OP_OUT_SVC]  = out_svc_evt;
        set_vec[OP_IN_DONE]  = in_done_evt;
        set_vec[OP_OUT_DONE] = out_done_evt;

        st_d = st_q;
        if (op_clr_we) begin
            st_d.op = st_q.op & ~wdata[OP_STICKY_W-1:0];
        end
        st_d.op = st_d.op | set_vec;
        if (mask_we) begin
            st_d.mask = wdata[MASK_W-1:0];
        end
        if (mode_we) begin
            st_d.mode = xfer_mode_e'(wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{op: '0, mask: '0, mode: XM_FIFO};
        end else begin
            st_q <= st_d;
        end
    end

    // mask reaches only the service flags, and only in the DMA styles
    always_comb begin
        eff_mask = '0;
        if (mode_is_dma(st_q.mode)) begin
            eff_mask[OP_IN_SVC]  = st_q.mask[0];
            eff_mask[OP_OUT_SVC] = st_q.mask[1];
        end
    end

    assign op_o    = st_q.op;
    assign mask_o  = st_q.mask;
    assign mode_o  = st_q.mode;
    assign cause_o = |(st_q.op & ~eff_mask);

endmodule

// File: rtl/sci_status_irq.sv
module sci_status_irq
    import sci_status_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = $clog2(2 * NUM_BANKS + 3)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    input  logic [NUM_BANKS*ERR_W-1:0] err_evt,
    input  logic                       in_svc_evt,
    input  logic                       out_svc_evt,
    input  logic                       in_done_evt,
    input  logic                       out_done_evt,
    input  logic                       out_fifo_full,
    input  logic                       in_fifo_nempty,
    output logic                       irq_o,
    output logic                       xfer_done_o
);

    localparam int A_OP   = 2 * NUM_BANKS;
    localparam int A_MASK = 2 * NUM_BANKS + 1;
    localparam int A_MODE = 2 * NUM_BANKS + 2;

    logic [NUM_BANKS*ERR_W-1:0] err_flags;
    logic [NUM_BANKS*ERR_W-1:0] err_en;
    logic [NUM_BANKS-1:0]       bank_cause;
    logic [OP_STICKY_W-1:0]     op_flags;
    logic [MASK_W-1:0]          op_mask;
    xfer_mode_e                 xfer_mode;
    logic                       op_cause;
    logic                       irq_d, irq_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_we, en_we;
        assign clr_we = wr_en && (wr_addr == ADDR_W'(2 * b));
        assign en_we  = wr_en && (wr_addr == ADDR_W'(2 * b + 1));

        sci_err_bank #(
            .REG_W(REG_W)
        ) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .flag_clr_we(clr_we),
            .en_we      (en_we),
            .wdata      (wr_data),
            .evt        (err_evt[b*ERR_W +: ERR_W]),
            .flags_o    (err_flags[b*ERR_W +: ERR_W]),
            .en_o       (err_en[b*ERR_W +: ERR_W]),
            .cause_o    (bank_cause[b])
        );
    end

    sci_op_reg #(
        .REG_W(REG_W)
    ) op_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_clr_we   (wr_en && (wr_addr == ADDR_W'(A_OP))),
        .mask_we     (wr_en && (wr_addr == ADDR_W'(A_MASK))),
        .mode_we     (wr_en && (wr_addr == ADDR_W'(A_MODE))),
        .wdata       (wr_data),
        .in_svc_evt  (in_svc_evt),
        .out_svc_evt (out_svc_evt),
        .in_done_evt (in_done_evt),
        .out_done_evt(out_done_evt),
        .op_o        (op_flags),
        .mask_o      (op_mask),
        .mode_o      (xfer_mode),
        .cause_o     (op_cause)
    );

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == ADDR_W'(2 * b)) begin
                rd_data[ERR_W-1:0] = err_flags[b*ERR_W +: ERR_W];
            end
            if (rd_addr == ADDR_W'(2 * b + 1)) begin
                rd_data[ERR_W-1:0] = err_en[b*ERR_W +: ERR_W];
            end
        end
        if (rd_addr == ADDR_W'(A_OP)) begin
            rd_data[OP_STICKY_W-1:0] = op_flags;
            rd_data[OP_OUT_FULL]     = out_fifo_full;
            rd_data[OP_IN_NEMPTY]    = in_fifo_nempty;
        end
        if (rd_addr == ADDR_W'(A_MASK)) begin
            rd_data[MASK_W-1:0] = op_mask;
        end
        if (rd_addr == ADDR_W'(A_MODE)) begin
            rd_data[MODE_W-1:0] = xfer_mode;
        end
    end

    always_comb begin
        irq_d = (|bank_cause) | op_cause;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o       = irq_q;
    assign xfer_done_o = op_flags[OP_IN_DONE] | (|err_flags);

endmodule

// File: rtl/sci_status_chk.sv
module sci_status_chk
    import sci_status_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [REG_W-1:0]           wr_data,
    input logic [NUM_BANKS*ERR_W-1:0] err_evt,
    input logic                       in_svc_evt,
    input logic                       in_done_evt,
    input logic [NUM_BANKS*ERR_W-1:0] err_flags,
    input logic [NUM_BANKS*ERR_W-1:0] err_en,
    input logic [OP_STICKY_W-1:0]     op_flags,
    input logic                       irq_o,
    input logic                       xfer_done_o
);

    localparam int A_OP = 2 * NUM_BANKS;

    // R1
    a_r1_reset_irq_low: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // R2
    a_r2_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & ~$past(err_flags) & ~$past(err_en)) == '0));

    // R3
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data[0] && !err_evt[0]) |=> !err_flags[0]);

    // R4
    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_OP) && wr_data[OP_IN_SVC] && in_svc_evt)
        |=> op_flags[OP_IN_SVC]);

    // R7
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|err_flags) || (|op_flags)));

    // R8
    a_r8_done_after_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        in_done_evt |=> xfer_done_o);

endmodule

bind sci_status_irq sci_status_chk #(
    .NUM_BANKS(NUM_BANKS),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .err_evt    (err_evt),
    .in_svc_evt (in_svc_evt),
    .in_done_evt(in_done_evt),
    .err_flags  (err_flags),
    .err_en     (err_en),
    .op_flags   (op_flags),
    .irq_o      (irq_o),
    .xfer_done_o(xfer_done_o)
);

// File: tb/sci_status_irq_tb.sv
`timescale 1ns/1ps
module sci_status_irq_tb_top;

    localparam int NB = 2;
    localparam int AW = 3;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic [NB*3-1:0] err_evt = '0;
    logic in_svc_evt = 1'b0, out_svc_evt = 1'b0, in_done_evt = 1'b0, out_done_evt = 1'b0;
    logic out_fifo_full = 1'b0, in_fifo_nempty = 1'b0;
    logic irq_o, xfer_done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_err [NB];
    int m_en  [NB];
    int m_op, m_mask, m_mode, m_irq;

    always #10 clk = ~clk;

    sci_status_irq #(.NUM_BANKS(NB), .REG_W(RW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .err_evt(err_evt),
        .in_svc_evt(in_svc_evt), .out_svc_evt(out_svc_evt),
        .in_done_evt(in_done_evt), .out_done_evt(out_done_evt),
        .out_fifo_full(out_fifo_full), .in_fifo_nempty(in_fifo_nempty),
        .irq_o(irq_o), .xfer_done_o(xfer_done_o)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_rd(int a);
        if (a < 2 * NB) return (a % 2 == 0) ? m_err[a / 2] : m_en[a / 2];
        if (a == 2 * NB) return m_op + (out_fifo_full ? 16 : 0) + (in_fifo_nempty ? 32 : 0);
        if (a == 2 * NB + 1) return m_mask;
        if (a == 2 * NB + 2) return m_mode;
        return 0;
    endfunction

    function automatic int model_done();
        int d = ((m_op & 4) != 0) ? 1 : 0;
        for (int b = 0; b < NB; b++) if (m_err[b] != 0) d = 1;
        return d;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin m_err[b] = 0; m_en[b] = 0; end
        m_op = 0; m_mask = 0; m_mode = 0; m_irq = 0;
    endtask

    task automatic model_clock();
        int cause = 0;
        int effm;
        int evt_op;
        int nerr [NB];
        int nen  [NB];
        int nop, nmask, nmode;
        effm = (m_mode >= 2) ? m_mask : 0;
        for (int b = 0; b < NB; b++) if ((m_err[b] & m_en[b]) != 0) cause = 1;
        if ((m_op & ~effm & 15) != 0) cause = 1;
        for (int b = 0; b < NB; b++) begin
            int clr = (wr_en && wr_addr == 2 * b) ? (wr_data & 7) : 0;
            int ev  = (err_evt >> (3 * b)) & 7;
            nerr[b] = (m_err[b] & ~clr) | (ev & m_en[b]);
            nen[b]  = (wr_en && wr_addr == 2 * b + 1) ? (wr_data & 7) : m_en[b];
        end
        evt_op = (in_svc_evt ? 1 : 0) + (out_svc_evt ? 2 : 0) + (in_done_evt ? 4 : 0) + (out_done_evt ? 8 : 0);
        nop   = (m_op & ~((wr_en && wr_addr == 2 * NB) ? (wr_data & 15) : 0)) | evt_op;
        nmask = (wr_en && wr_addr == 2 * NB + 1) ? (wr_data & 3) : m_mask;
        nmode = (wr_en && wr_addr == 2 * NB + 2) ? (wr_data & 3) : m_mode;
        for (int b = 0; b < NB; b++) begin m_err[b] = nerr[b]; m_en[b] = nen[b]; end
        m_op = nop; m_mask = nmask; m_mode = nmode; m_irq = cause;
    endtask

    // one clock: inputs already driven; model steps; compare at negedge; pulses drop
    task automatic tick(string rd_tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check("R7 irq", int'(irq_o), m_irq);
        check("R8 done", int'(xfer_done_o), model_done());
        check(rd_tag, int'(rd_data), model_rd(int'(rd_addr)));
        wr_en = 1'b0; err_evt = '0;
        in_svc_evt = 1'b0; out_svc_evt = 1'b0; in_done_evt = 1'b0; out_done_evt = 1'b0;
    endtask

    task automatic wr(int a, int d, string tag);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = RW'(d); rd_addr = AW'(a);
        tick(tag);
    endtask

    task automatic idle(int a, string tag);
        rd_addr = AW'(a);
        tick(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every address zero after reset
        for (int a = 0; a < 7; a++) idle(a, "R1 reset readback");
        check("R1 irq after reset", int'(irq_o), 0);

        // R2: disabled bit ignored
        err_evt = 6'b000_001; rd_addr = 0; tick("R2 disabled event");
        check("R2 disabled flag", int'(rd_data), 0);

        // R9: enables readback
        wr(1, 8'hFF, "R9 bank0 enable");
        check("R9 enable low bits only", int'(rd_data), 7);
        wr(3, 8'h02, "R9 bank1 enable");

        // R2: enabled capture, irq one cycle later (R7)
        err_evt = 6'b000_101; rd_addr = 0; tick("R2 capture");
        check("R2 flags 5", int'(rd_data), 5);
        check("R7 irq lags flags", int'(irq_o), 0);
        idle(0, "R7 irq follows");
        check("R7 irq high", int'(irq_o), 1);
        check("R8 done by error", int'(xfer_done_o), 1);

        // R3: clear exactly bit 0
        wr(0, 8'h01, "R3 partial clear");
        check("R3 bit2 kept", int'(rd_data), 4);

        // R4: clear and event on bit 2 together
        wr_en = 1'b1; wr_addr = 0; wr_data = 8'h04; err_evt = 6'b000_100; rd_addr = 0;
        tick("R4 error set wins");
        check("R4 error bit stays", int'(rd_data), 4);
        wr(0, 8'h04, "R3 full clear");
        check("R3 cleared", int'(rd_data), 0);
        idle(0, "R7 settle");
        check("R7 irq drops", int'(irq_o), 0);

        // bank1 enabled only bit1
        err_evt = 6'b111_000; rd_addr = 2; tick("R2 bank1 capture");
        check("R2 bank1 only bit1", int'(rd_data), 2);
        wr(2, 8'hFF, "R3 bank1 clear");

        // R5 / R6: FIFO mode ignores mask
        wr(5, 8'hFF, "R9 mask");
        check("R9 mask low bits", int'(rd_data), 3);
        in_svc_evt = 1'b1; rd_addr = 4; tick("R5 in service");
        idle(4, "R6 fifo unmasked");
        check("R6 fifo irq", int'(irq_o), 1);
        wr(6, 8'h02, "R6 mode dma a");
        check("R9 mode", int'(rd_data), 2);
        idle(4, "R6 dma masked");
        check("R6 dma masks service", int'(irq_o), 0);
        wr(6, 8'h03, "R6 mode dma b");
        idle(4, "R6 dma b masked");
        check("R6 dma b masks", int'(irq_o), 0);
        wr(6, 8'h01, "R6 mode block");
        idle(4, "R6 block unmasked");
        check("R6 block irq", int'(irq_o), 1);
        wr(6, 8'h02, "R6 back to dma");
        out_done_evt = 1'b1; rd_addr = 4; tick("R5 out done");
        idle(4, "R6 done not masked");
        check("R6 done unmasked", int'(irq_o), 1);

        // R5: live status and write to bits 4/5
        out_fifo_full = 1'b1; in_fifo_nempty = 1'b1;
        wr(4, 8'h30, "R5 status write ignored");
        check("R5 live bits", int'(rd_data), 16 + 32 + 8 + 1);
        out_fifo_full = 1'b0;
        wr(4, 8'h09, "R5 w1c op");
        check("R5 op cleared", int'(rd_data), 32);

        // R4 on operational flag
        wr_en = 1'b1; wr_addr = 4; wr_data = 8'h01; in_svc_evt = 1'b1; rd_addr = 4;
        tick("R4 op set wins");
        check("R4 op bit stays", int'(rd_data), 33);

        // R8: in_done drives done
        in_done_evt = 1'b1; rd_addr = 4; tick("R8 in done");
        check("R8 done high", int'(xfer_done_o), 1);
        wr(4, 8'h04, "R8 clear done");
        check("R8 done low", int'(xfer_done_o), 0);
        idle(4, "R7 final");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule